// File: doc/BRIEF.md
# SPI Master Mode-Fault Supervisor

This block guards an SPI controller that runs as bus master on a bus where the slave-select line is shared with other possible masters. While the controller is enabled in master mode, a low level on that select input means another master has claimed the bus. The supervisor then turns the controller off at once and raises a sticky fault flag. Software clears the flag by reading the status register. It brings the controller back by writing the enable command again.

The supervisor holds three pieces of state: the enable level handed to the shifter, the sticky fault flag, and a configuration bit that switches detection off. The select input is asynchronous to the block clock. It passes through a synchronizer before it is evaluated.

Top module: `spi_modefault_guard`

## Requirements
- R1: A fault is raised only when `master_mode_i` is 1, the controller is enabled, detection is switched on, and the synchronized `sel_ni` is 0. A value of 0 means another master is driving the line.
- R2: `fault_o` stays 1 until a cycle with `status_rd_i` = 1 and no new fault. It reads 0 after the next rising edge.
- R3: At the edge where `fault_o` rises, `en_o` falls to 0.
- R4: Once disabled, `en_o` stays 0 until a cycle with `en_cmd_i` = 1 and `dis_cmd_i` = 0.
- R5: After reset, `en_o` = 0, `fault_o` = 0, and detection is switched on.
- R6: Writing 1 through `cfg_wr_i`/`cfg_det_off_i` switches detection off, and no fault is raised for any select level. Writing 0 switches it back on.
- R7: `sel_ni` passes through two flip-flops. After it goes low, the fault appears at the third rising edge and not at the second.
- R8: A fault in the same cycle as a status read leaves `fault_o` at 1.
- R9: An enable command while `sel_ni` is still low sets `en_o` to 1 for one cycle. The fault is then raised again and `en_o` returns to 0.
- R10: A disable command has priority over an enable command in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_mode_i | input | 1 | Controller configured as master |
| sel_ni | input | 1 | Shared slave-select line, asynchronous, 0 = driven by a master |
| en_cmd_i | input | 1 | Enable command strobe |
| dis_cmd_i | input | 1 | Disable command strobe |
| status_rd_i | input | 1 | Status register read strobe |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_det_off_i | input | 1 | Value written to the detection-off bit |
| en_o | output | 1 | Enable level to the shifter |
| fault_o | output | 1 | Sticky mode-fault flag |

## Verification
The hardest cases are the collisions: a fault that lands in exactly the cycle of a status read, and an enable command issued while the foreign master still holds the line. Both need the synchronizer delay counted exactly. The bench drops the select line at a falling edge and places the read strobe in the cycle after the second rising edge, where the fault is evaluated. It then clears the flag and pulses enable with the line still low, and watches `en_o` rise for one cycle and fall again. The remaining behaviour is swept over every combination of master mode, detection-off and enable state.

// File: rtl/mf_pkg.sv
package mf_pkg;
  localparam int unsigned SyncStages = 2;
endpackage

// File: rtl/mf_sync.sv
module mf_sync #(
  parameter int unsigned Stages = 2,
  parameter logic        RstVal = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [Stages-1:0] pipe_q;

  for (genvar g = 0; g < Stages; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q[g] <= RstVal;
        else         pipe_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q[g] <= RstVal;
        else         pipe_q[g] <= pipe_q[g-1];
    end
  end

  assign q_o = pipe_q[Stages-1];
endmodule

// File: rtl/mf_enable_ctl.sv
module mf_enable_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_evt_i,
  input  logic en_cmd_i,
  input  logic dis_cmd_i,
  output logic en_o
);
  logic en_q;

  // fault beats disable beats enable
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          en_q <= 1'b0;
    else if (fault_evt_i) en_q <= 1'b0;
    else if (dis_cmd_i)   en_q <= 1'b0;
    else if (en_cmd_i)    en_q <= 1'b1;

  assign en_o = en_q;

  AST_DIS_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_cmd_i |=> !en_q); // R10
  AST_STAYS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !en_cmd_i) |=> !en_q); // R4
endmodule

// File: rtl/mf_fault_flag.sv
module mf_fault_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_evt_i,
  input  logic status_rd_i,
  output logic fault_o
);
  logic fault_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          fault_q <= 1'b0;
    else if (fault_evt_i) fault_q <= 1'b1;
    else if (status_rd_i) fault_q <= 1'b0;

  assign fault_o = fault_q;

  AST_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_rd_i && !fault_evt_i) |=> !fault_q); // R2
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && !status_rd_i) |=> fault_q); // R2
  AST_EVT_WINS_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_evt_i && status_rd_i) |=> fault_q); // R8
endmodule

// File: rtl/spi_modefault_guard.sv
module spi_modefault_guard
  import mf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_mode_i,
  input  logic sel_ni,
  input  logic en_cmd_i,
  input  logic dis_cmd_i,
  input  logic status_rd_i,
  input  logic cfg_wr_i,
  input  logic cfg_det_off_i,
  output logic en_o,
  output logic fault_o
);
  logic sel_s, det_off_q, fault_evt, en_w, fault_w;

  mf_sync #(.Stages(SyncStages), .RstVal(1'b1)) i_sync (
    .clk_i, .rst_ni, .d_i(sel_ni), .q_o(sel_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       det_off_q <= 1'b0;
    else if (cfg_wr_i) det_off_q <= cfg_det_off_i;

  assign fault_evt = master_mode_i & en_w & ~det_off_q & ~sel_s;

  mf_enable_ctl i_en (
    .clk_i, .rst_ni, .fault_evt_i(fault_evt),
    .en_cmd_i, .dis_cmd_i, .en_o(en_w)
  );

  mf_fault_flag i_flag (
    .clk_i, .rst_ni, .fault_evt_i(fault_evt),
    .status_rd_i, .fault_o(fault_w)
  );

  assign en_o    = en_w;
  assign fault_o = fault_w;

  AST_FAULT_KILLS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_w) |-> !en_w); // R3
  AST_SLAVE_NO_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_mode_i && !fault_w) |=> !fault_w); // R1
  AST_DET_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_off_q && !fault_w) |=> !fault_w); // R6
  AST_SEL_HIGH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_s && !fault_w) |=> !fault_w); // R7
endmodule

// File: tb/test_spi_modefault_guard.sv
module test_spi_modefault_guard;
  logic clk = 1'b0, rst_n = 1'b0;
  logic master_mode = 0, sel_n = 1, en_cmd = 0, dis_cmd = 0, st_rd = 0;
  logic cfg_wr = 0, cfg_off = 0;
  logic en, fault;
  int   n_run = 0, n_fail = 0;
  bit   done = 0;

  always #10 clk = ~clk;

  spi_modefault_guard i_spi_modefault_guard (
    .clk_i(clk), .rst_ni(rst_n), .master_mode_i(master_mode), .sel_ni(sel_n),
    .en_cmd_i(en_cmd), .dis_cmd_i(dis_cmd), .status_rd_i(st_rd),
    .cfg_wr_i(cfg_wr), .cfg_det_off_i(cfg_off), .en_o(en), .fault_o(fault)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic act_en, logic act_f, logic exp_en, logic exp_f);
    n_run++;
    if (act_en !== exp_en || act_f !== exp_f) begin
      n_fail++;
      $display("FAIL %s: en=%b fault=%b expected en=%b fault=%b", req, act_en, act_f, exp_en, exp_f);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; master_mode = 0; sel_n = 1; en_cmd = 0; dis_cmd = 0;
    st_rd = 0; cfg_wr = 0; cfg_off = 0;
    step(2); rst_n = 1; step(1);
  endtask

  task automatic pulse_en();
    en_cmd = 1; step(1); en_cmd = 0;
  endtask

  task automatic pulse_rd();
    st_rd = 1; step(1); st_rd = 0;
  endtask

  initial begin
    do_reset();
    chk("R5 reset", en, fault, 0, 0);

    // R1 R3 R6: sweep master mode x detection off x enabled
    for (int m = 0; m < 2; m++)
      for (int off = 0; off < 2; off++)
        for (int e = 0; e < 2; e++) begin
          logic ef;
          do_reset();
          cfg_wr = 1; cfg_off = off[0]; step(1); cfg_wr = 0;
          master_mode = m[0];
          if (e) pulse_en();
          sel_n = 0; step(3);
          ef = m[0] & ~off[0] & e[0];
          chk(off ? "R6 det off" : "R1 sweep", en, fault, e[0] & ~ef, ef);
          sel_n = 1; step(3);
          chk("R2 sticky", en, fault, e[0] & ~ef, ef);
          pulse_rd();
          chk("R2 read clears", en, fault, e[0] & ~ef, 0);
        end

    // R7 synchronizer latency
    do_reset(); master_mode = 1; pulse_en();
    sel_n = 0; step(2);
    chk("R7 not at 2nd edge", en, fault, 1, 0);
    step(1);
    chk("R7 at 3rd edge", en, fault, 0, 1);

    // R4 stays disabled after line releases
    sel_n = 1; step(5);
    chk("R4 stays off", en, fault, 0, 1);
    pulse_rd(); pulse_en();
    chk("R4 re-enable", en, fault, 1, 0);

    // R8 fault coinciding with read
    sel_n = 0; step(2);
    st_rd = 1; step(1); st_rd = 0;
    chk("R8 fault wins read", en, fault, 0, 1);

    // R9 enable while line still low
    pulse_rd();
    chk("R9 cleared", en, fault, 0, 0);
    pulse_en();
    chk("R9 enable takes", en, fault, 1, 0);
    step(1);
    chk("R9 fault again", en, fault, 0, 1);

    // R10 disable priority
    do_reset();
    en_cmd = 1; dis_cmd = 1; step(1); en_cmd = 0; dis_cmd = 0;
    chk("R10 both", en, fault, 0, 0);
    pulse_en();
    dis_cmd = 1; step(1); dis_cmd = 0;
    chk("R10 disable", en, fault, 0, 0);

    // R6 switch detection back on
    do_reset(); master_mode = 1;
    cfg_wr = 1; cfg_off = 1; step(1); cfg_wr = 0;
    pulse_en(); sel_n = 0; step(6);
    chk("R6 off holds", en, fault, 1, 0);
    cfg_wr = 1; cfg_off = 0; step(1); cfg_wr = 0; step(1);
    chk("R6 back on", en, fault, 0, 1);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); n_run++; n_fail++; $display("FAIL watchdog"); end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule